// File: doc/BRIEF.md
# Flash Sector Lock Register Bank

This block keeps the protection state for every sector of a small firmware flash. It has one lock register per sector, and each register holds three bits: a write-lock bit, a read-lock bit, and a sticky lock-down bit. The block also watches two active-low hardware pins. The top-lock pin covers the highest sector. The write-protect pin covers every other sector. From the register bits and the two pins, the block produces these outputs for the flash core:

- a program/erase permission for each sector;
- a read mask for each sector;
- a masked copy of the array read data;
- a pulse and a sticky flag when a program or erase attempt is refused.

Software reaches the lock registers through a simple synchronous register port. The port has an address, a write enable, byte-wide write data, and byte-wide read data that arrives one cycle after the address. The flash core reports each program or erase attempt with a request strobe and a sector number. It reads the permission vector directly, and it passes array data through the mask.

Top module: `sector_lock_bank`

## Requirements
- R1: The reset input is asynchronous and active-low. While it is asserted, and after it is released, every lock register reads 0x01: write-lock is 1, lock-down is 0 and read-lock is 0. After reset the sticky error flag reads 0.
- R2: The lock register for sector n sits at address 0xFFB8_0002 + n·0x1_0000. Its bit 0 is write-lock, bit 1 is lock-down and bit 2 is read-lock. Bits 7:3 always read 0, and writes to them are discarded. Read data appears on the cycle after the address is presented. A write changes only the addressed sector.
- R3: A read from any address that is not a lock register returns 0x00. A write to such an address changes no lock register.
- R4: While a sector's write-lock bit is 1, its permission output is 0. With both pins high and write-lock 0, its permission output is 1.
- R5: While the read-lock bit of the sector being read is 1, the array data output is 0x00 and that sector's read-mask bit is 1. Otherwise the array data passes through unchanged.
- R6: Once a sector's lock-down bit is 1, every later write to that sector's register is ignored until reset. While lock-down is 0, a write updates all three bits, including lock-down itself.
- R7: While the top-lock pin is low, the highest sector has no program/erase permission, whatever its write-lock bit. The other sectors are not affected by this pin.
- R8: While the write-protect pin is low, every sector except the highest has no program/erase permission, whatever its write-lock bit. The highest sector is not affected by this pin.
- R9: A program or erase request to a sector without permission raises the error pulse for exactly one cycle, starting on the cycle after the request. The same request sets the sticky error flag. The status-clear input clears the sticky flag, but a refused request in the same cycle takes priority. A request to a permitted sector raises neither output.
- R10: Reset clears lock-down and restores every lock register to its default, so the register can be written again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 32 | Register port address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Register read data, one cycle after the address |
| top_lock_n | input | 1 | Active-low protect pin for the highest sector |
| wp_n | input | 1 | Active-low protect pin for all other sectors |
| pe_req | input | 1 | Program/erase attempt strobe from the flash core |
| pe_sector | input | 3 | Target sector of the attempt |
| pe_allow | output | 8 | Program/erase permission, one bit per sector |
| arr_sector | input | 3 | Sector of the current array read |
| arr_data_in | input | 8 | Raw array read data |
| arr_data_out | output | 8 | Array read data after read-lock masking |
| rd_mask | output | 8 | Read-lock state, one bit per sector |
| status_clr | input | 1 | Clears the sticky error flag |
| err_pulse | output | 1 | One-cycle pulse for a refused attempt |
| err_sticky | output | 1 | Sticky error flag for refused attempts |

## Verification
The bench builds the block with its default parameters: eight sectors, a 32-bit address, a 64 KiB stride and the base that places sector 0 at 0xFFB8_0002. With eight sectors, both pins have sectors to cover. The top-lock pin covers one sector and the write-protect pin covers seven, so each test can check a pin against both the sectors it covers and the ones it does not. The 16-bit stride leaves low-order addresses between the registers and an address just past the last sector. The bench uses these to show that decoding misses return zero and change nothing.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;
  localparam int unsigned LOCK_FIELD_W = 3;

  typedef struct packed {
    logic rd_lock;
    logic frozen;
    logic wr_lock;
  } lock_bits_t;

  localparam lock_bits_t LOCK_DEFAULT = '{rd_lock: 1'b0, frozen: 1'b0, wr_lock: 1'b1};

  function automatic lock_bits_t bits_from_byte(input logic [7:0] b);
    lock_bits_t r;
    r.wr_lock = b[0];
    r.frozen  = b[1];
    r.rd_lock = b[2];
    return r;
  endfunction

  function automatic logic [7:0] byte_from_bits(input lock_bits_t l);
    return {5'b0, l.rd_lock, l.frozen, l.wr_lock};
  endfunction
endpackage

// File: rtl/slk_addr_decode.sv
module slk_addr_decode #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned STRIDE_LG   = 16,
  parameter logic [ADDR_W-1:0] BASE  = 32'hFFB8_0002,
  localparam int unsigned IDX_W      = $clog2(NUM_SECTORS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned UPPER_W = ADDR_W - STRIDE_LG;
  localparam logic [UPPER_W-1:0] SECT_LIMIT = UPPER_W'(NUM_SECTORS);

  logic [ADDR_W-1:0]    offset;
  logic [UPPER_W-1:0]   upper;
  logic [STRIDE_LG-1:0] lower;

  always_comb begin
    offset = addr - BASE;
    upper  = offset[ADDR_W-1:STRIDE_LG];
    lower  = offset[STRIDE_LG-1:0];
    hit    = (lower == '0) && (upper < SECT_LIMIT);
    idx    = upper[IDX_W-1:0];
  end
endmodule

// File: rtl/slk_sector_reg.sv
module slk_sector_reg
  import sector_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  lock_bits_t wr_bits,
  output lock_bits_t q
);
  lock_bits_t d;
  logic       upd_en;

  always_comb begin
    upd_en = wr_stb && !q.frozen;
    d      = upd_en ? wr_bits : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= LOCK_DEFAULT;
    else if (upd_en) q <= d;
  end
endmodule

// File: rtl/slk_protect_combine.sv
module slk_protect_combine #(
  parameter int unsigned NUM_SECTORS = 8
) (
  input  logic [NUM_SECTORS-1:0] wl_vec,
  input  logic [NUM_SECTORS-1:0] rl_vec,
  input  logic                   top_lock_n,
  input  logic                   wp_n,
  output logic [NUM_SECTORS-1:0] allow_vec,
  output logic [NUM_SECTORS-1:0] mask_vec
);
  localparam int unsigned TOP = NUM_SECTORS - 1;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sect
    logic pin_prot;
    if (s == TOP) begin : g_top
      assign pin_prot = !top_lock_n;
    end else begin : g_main
      assign pin_prot = !wp_n;
    end
    assign allow_vec[s] = !(wl_vec[s] || pin_prot);
    assign mask_vec[s]  = rl_vec[s];
  end
endmodule

// File: rtl/sector_lock_bank.sv
module sector_lock_bank
  import sector_lock_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STRIDE_LG   = 16,
  parameter logic [ADDR_W-1:0] BASE  = 32'hFFB8_0002,
  localparam int unsigned SEC_W      = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr_en,
  input  logic [7:0]             reg_wr_data,
  output logic [7:0]             reg_rd_data,
  input  logic                   top_lock_n,
  input  logic                   wp_n,
  input  logic                   pe_req,
  input  logic [SEC_W-1:0]       pe_sector,
  output logic [NUM_SECTORS-1:0] pe_allow,
  input  logic [SEC_W-1:0]       arr_sector,
  input  logic [DATA_W-1:0]      arr_data_in,
  output logic [DATA_W-1:0]      arr_data_out,
  output logic [NUM_SECTORS-1:0] rd_mask,
  input  logic                   status_clr,
  output logic                   err_pulse,
  output logic                   err_sticky
);
  logic             dec_hit;
  logic [SEC_W-1:0] dec_idx;

  slk_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_SECTORS(NUM_SECTORS),
    .STRIDE_LG(STRIDE_LG), .BASE(BASE)
  ) u_dec (
    .addr(reg_addr), .hit(dec_hit), .idx(dec_idx)
  );

  lock_bits_t             lock_q [NUM_SECTORS];
  lock_bits_t             wr_bits;
  logic [NUM_SECTORS-1:0] wl_q, rl_q, ld_q;

  assign wr_bits = bits_from_byte(reg_wr_data);

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_reg
    logic stb;
    assign stb = reg_wr_en && dec_hit && (dec_idx == SEC_W'(s));
    slk_sector_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr_stb(stb), .wr_bits(wr_bits), .q(lock_q[s])
    );
    assign wl_q[s] = lock_q[s].wr_lock;
    assign rl_q[s] = lock_q[s].rd_lock;
    assign ld_q[s] = lock_q[s].frozen;
  end

  slk_protect_combine #(.NUM_SECTORS(NUM_SECTORS)) u_prot (
    .wl_vec(wl_q), .rl_vec(rl_q), .top_lock_n(top_lock_n), .wp_n(wp_n),
    .allow_vec(pe_allow), .mask_vec(rd_mask)
  );

  assign arr_data_out = rd_mask[arr_sector] ? '0 : arr_data_in;

  // register read path
  logic [7:0] rd_d;
  always_comb begin
    rd_d = 8'h00;
    if (dec_hit) rd_d = byte_from_bits(lock_q[dec_idx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rd_data <= 8'h00;
    else        reg_rd_data <= rd_d;
  end

  // refused-attempt reporting
  logic refused, pulse_d, sticky_d, sticky_en;
  always_comb begin
    refused   = pe_req && !pe_allow[pe_sector];
    pulse_d   = refused;
    sticky_en = refused || status_clr;
    sticky_d  = refused;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_sticky <= 1'b0;
    else if (sticky_en) err_sticky <= sticky_d;
  end
endmodule

// File: rtl/slk_checker.sv
module slk_checker #(
  parameter int unsigned NUM_SECTORS = 8,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned SEC_W      = $clog2(NUM_SECTORS),
  localparam int unsigned TOP        = NUM_SECTORS - 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   top_lock_n,
  input logic                   wp_n,
  input logic                   pe_req,
  input logic [SEC_W-1:0]       pe_sector,
  input logic [NUM_SECTORS-1:0] pe_allow,
  input logic [SEC_W-1:0]       arr_sector,
  input logic [DATA_W-1:0]      arr_data_out,
  input logic [NUM_SECTORS-1:0] rd_mask,
  input logic                   status_clr,
  input logic                   err_pulse,
  input logic                   err_sticky,
  input logic [NUM_SECTORS-1:0] wl_q,
  input logic [NUM_SECTORS-1:0] rl_q,
  input logic [NUM_SECTORS-1:0] ld_q
);
  AST_WL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (wl_q & pe_allow) == '0); // R4
  AST_TOP_PIN: assert property (@(posedge clk) disable iff (!rst_n) !top_lock_n |-> !pe_allow[TOP]); // R7
  AST_WP_PIN: assert property (@(posedge clk) disable iff (!rst_n) !wp_n |-> (pe_allow[TOP-1:0] == '0)); // R8
  AST_RD_MASK: assert property (@(posedge clk) disable iff (!rst_n) rd_mask[arr_sector] |-> (arr_data_out == '0)); // R5
  AST_ERR_FIRE: assert property (@(posedge clk) disable iff (!rst_n) (pe_req && !pe_allow[pe_sector]) |=> (err_pulse && err_sticky)); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(pe_req && !pe_allow[pe_sector]) |=> !err_pulse); // R9
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n) (status_clr && !(pe_req && !pe_allow[pe_sector])) |=> !err_sticky); // R9

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_ld
    AST_LD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) ld_q[s] |=> (ld_q[s] && $stable(wl_q[s]) && $stable(rl_q[s]))); // R6
  end
endmodule

bind sector_lock_bank slk_checker #(.NUM_SECTORS(NUM_SECTORS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .top_lock_n(top_lock_n), .wp_n(wp_n),
  .pe_req(pe_req), .pe_sector(pe_sector), .pe_allow(pe_allow),
  .arr_sector(arr_sector), .arr_data_out(arr_data_out), .rd_mask(rd_mask),
  .status_clr(status_clr), .err_pulse(err_pulse), .err_sticky(err_sticky),
  .wl_q(wl_q), .rl_q(rl_q), .ld_q(ld_q)
);

// File: tb/sector_lock_bank_tb_top.sv
module sector_lock_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] reg_addr;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_data;
  logic [7:0]  reg_rd_data;
  logic        top_lock_n, wp_n, pe_req, status_clr;
  logic [2:0]  pe_sector, arr_sector;
  logic [7:0]  pe_allow, rd_mask, arr_data_in, arr_data_out;
  logic        err_pulse, err_sticky;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sector_lock_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .top_lock_n(top_lock_n), .wp_n(wp_n), .pe_req(pe_req), .pe_sector(pe_sector),
    .pe_allow(pe_allow), .arr_sector(arr_sector), .arr_data_in(arr_data_in),
    .arr_data_out(arr_data_out), .rd_mask(rd_mask), .status_clr(status_clr),
    .err_pulse(err_pulse), .err_sticky(err_sticky)
  );

  function automatic logic [31:0] sect_addr(input int n);
    return 32'hFFB8_0002 + (32'(n) << 16);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [31:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int s = 0; s < 8; s++) begin
      reg_read(sect_addr(s), v);
      check("R1 default", 32'(v), 32'h01);
    end
    check("R1 sticky", 32'(err_sticky), 0);
    check("R4 all locked", 32'(pe_allow), 32'h00);
  endtask

  task automatic t_map();
    logic [7:0] v;
    reg_write(sect_addr(3), 8'hFC);
    reg_read(sect_addr(3), v);
    check("R2 high bits discarded", 32'(v), 32'h04);
    reg_read(sect_addr(4), v);
    check("R2 neighbour untouched", 32'(v), 32'h01);
    reg_read(sect_addr(2), v);
    check("R2 neighbour untouched", 32'(v), 32'h01);
    check("R4 sector3 allowed", 32'(pe_allow), 32'h08);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    reg_write(32'hFFB8_0003, 8'h00);
    reg_write(32'hFFC0_0002, 8'h00);
    reg_read(sect_addr(0), v);
    check("R3 write miss no effect", 32'(v), 32'h01);
    reg_read(32'hFFB8_0003, v);
    check("R3 read miss", 32'(v), 32'h00);
    reg_read(32'hFFC0_0002, v);
    check("R3 read past last", 32'(v), 32'h00);
  endtask

  task automatic t_wlock();
    reg_write(sect_addr(2), 8'h00);
    check("R4 cleared allows", 32'(pe_allow[2]), 1);
    reg_write(sect_addr(2), 8'h01);
    check("R4 set blocks", 32'(pe_allow[2]), 0);
    reg_write(sect_addr(2), 8'h00);
  endtask

  task automatic t_rdlock();
    @(negedge clk);
    arr_data_in = 8'hA5; arr_sector = 3'd3;
    #1;
    check("R5 masked data", 32'(arr_data_out), 32'h00);
    check("R5 mask vector", 32'(rd_mask), 32'h08);
    arr_sector = 3'd2;
    #1;
    check("R5 passthrough", 32'(arr_data_out), 32'hA5);
  endtask

  task automatic t_err();
    @(negedge clk);
    pe_req = 1'b1; pe_sector = 3'd0;
    @(negedge clk);
    pe_req = 1'b0;
    check("R9 pulse", 32'(err_pulse), 1);
    check("R9 sticky set", 32'(err_sticky), 1);
    @(negedge clk);
    check("R9 pulse one cycle", 32'(err_pulse), 0);
    check("R9 sticky holds", 32'(err_sticky), 1);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    check("R9 clear", 32'(err_sticky), 0);
    pe_req = 1'b1; pe_sector = 3'd2;
    @(negedge clk);
    pe_req = 1'b0;
    check("R9 allowed no pulse", 32'(err_pulse), 0);
    check("R9 allowed no sticky", 32'(err_sticky), 0);
    pe_req = 1'b1; pe_sector = 3'd0; status_clr = 1'b1;
    @(negedge clk);
    pe_req = 1'b0; status_clr = 1'b0;
    check("R9 set beats clear", 32'(err_sticky), 1);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
  endtask

  task automatic t_pins();
    reg_write(sect_addr(7), 8'h00);
    check("R7 top allowed", 32'(pe_allow[7]), 1);
    top_lock_n = 1'b0;
    #1;
    check("R7 top pin blocks", 32'(pe_allow[7]), 0);
    check("R7 main unaffected", 32'(pe_allow[6:0]), 32'h0C);
    top_lock_n = 1'b1; wp_n = 1'b0;
    #1;
    check("R8 main blocked", 32'(pe_allow[6:0]), 32'h00);
    check("R8 top unaffected", 32'(pe_allow[7]), 1);
    wp_n = 1'b1;
    #1;
  endtask

  task automatic t_lockdown();
    logic [7:0] v;
    reg_write(sect_addr(5), 8'h02);
    reg_read(sect_addr(5), v);
    check("R6 lock-down write", 32'(v), 32'h02);
    reg_write(sect_addr(5), 8'h05);
    reg_read(sect_addr(5), v);
    check("R6 frozen", 32'(v), 32'h02);
    check("R6 still allowed", 32'(pe_allow[5]), 1);
    do_reset();
    reg_read(sect_addr(5), v);
    check("R10 reset restores", 32'(v), 32'h01);
    reg_write(sect_addr(5), 8'h00);
    reg_read(sect_addr(5), v);
    check("R10 writable again", 32'(v), 32'h00);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
    top_lock_n = 1'b1; wp_n = 1'b1; pe_req = 1'b0; pe_sector = '0;
    arr_sector = '0; arr_data_in = '0; status_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_unused();
    t_wlock();
    t_rdlock();
    t_err();
    t_pins();
    t_lockdown();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule